// File: doc/BRIEF.md
# Load-Use and Branch Penalty Accounting Monitor

This block watches the instruction stream of a simple in-order pipeline at retirement and tallies the cycles lost to two hazards. The first is a load whose result is consumed by the instruction right after it. The second is a control transfer that redirects fetch. Each cycle the pipeline may present one retiring instruction. The descriptor carries a class code, two source register numbers each qualified by a valid flag, a destination register (used only by loads) and a taken flag (used only by control transfers).

A two-state hazard machine remembers whether the previous retired instruction was a load. The states are `HZ_CLEAR` (no load result outstanding) and `HZ_LOAD_PEND` (the last retired instruction was a load; its destination is held as a one-hot pending mask).

The transitions are:
- `HZ_CLEAR` to `HZ_LOAD_PEND` on a retiring load.
- `HZ_LOAD_PEND` to `HZ_LOAD_PEND` on a further load, which replaces the pending mask.
- `HZ_LOAD_PEND` to `HZ_CLEAR` on any retiring non-load.
- Any state to `HZ_CLEAR` on clear.

Idle cycles leave the state untouched. While the machine is in `HZ_LOAD_PEND`, the pending mask forms the scoreboard that the next instruction's source operands are probed against. Each operand is probed on its own.

Four saturating counters hold the outputs: the load-stall total, the branch-stall total, the taken count and the untaken count. A synchronous clear zeroes them together with the hazard state. Counter width and register count are parameters.

Top module: `stall_accounting_monitor`

## Requirements
- R1: After reset, and in the cycle after `clr` is sampled high, all four outputs read zero.
- R2: When the instruction retiring right after a load names the load's destination in a valid, probed source, the load-stall total rises by 2 for each such source. Two sources naming that register charge 4.
- R3: A source whose valid flag is low never adds load-stall cycles, even when its register number matches the pending load.
- R4: Class codes are 0 execute, 1 compare, 2 multiply-accumulate, 3 control transfer, 4 load and 5 store. Classes 0 to 2 probe both sources. Class 3 probes only source A. Classes 4 and 5 probe none.
- R5: A load's destination is charged only to the next retiring instruction of any class. Idle cycles (`instr_valid` low) in between do not discard it, and it no longer applies after that next instruction.
- R6: A retiring class-3 instruction with `branch_taken` high adds 2 to the branch-stall total and 1 to the taken count.
- R7: A retiring class-3 instruction with `branch_taken` low adds 1 to the untaken count and leaves the branch-stall total unchanged.
- R8: Class codes 6 and 7 change no output. They still end a pending load's window.
- R9: Every total saturates at its all-ones value instead of wrapping.
- R10: `clr` discards a pending load. An instruction presented in the same cycle as `clr` is not counted.
- R11: Outputs are registered. They change only at the clock edge that samples a retiring instruction or `clr`, and they hold through idle cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of totals and hazard state |
| instr_valid | input | 1 | An instruction retires this cycle |
| instr_class | input | 3 | Class code of the retiring instruction |
| src_a | input | REG_W (4) | Source A register number |
| src_a_valid | input | 1 | Source A names a register |
| src_b | input | REG_W (4) | Source B register number |
| src_b_valid | input | 1 | Source B names a register |
| dst_reg | input | REG_W (4) | Destination of a load |
| branch_taken | input | 1 | Control transfer was taken |
| load_stall_total | output | CNT_W (32) | Accumulated load-use stall cycles |
| branch_stall_total | output | CNT_W (32) | Accumulated taken-branch penalty cycles |
| taken_count | output | CNT_W (32) | Number of taken control transfers |
| untaken_count | output | CNT_W (32) | Number of untaken control transfers |

## Verification
Every accounting effect of an instruction is due exactly one clock edge after the cycle it is presented in. The bench drives each descriptor on a falling edge and holds it for one full cycle. It reads the totals at the next falling edge, after the capturing rising edge has updated the registers.

A load's hazard effect spans two instructions. For that reason each hazard scenario issues the load first and then checks the totals after the consumer, measured against values tracked in the bench. Saturation runs in a narrow-counter instance, so the all-ones limit is reached within a few hundred instructions.

// File: rtl/stall_acct_pkg.sv
package stall_acct_pkg;

    localparam logic [2:0] CLS_EXEC   = 3'd0;
    localparam logic [2:0] CLS_CMP    = 3'd1;
    localparam logic [2:0] CLS_MAC    = 3'd2;
    localparam logic [2:0] CLS_BRANCH = 3'd3;
    localparam logic [2:0] CLS_LOAD   = 3'd4;
    localparam logic [2:0] CLS_STORE  = 3'd5;

    localparam int unsigned NUM_SRC   = 2;
    localparam int unsigned NUM_TALLY = 4;
    localparam int unsigned INC_W     = 3;

    // tally slots
    localparam int unsigned T_LOAD    = 0;
    localparam int unsigned T_BRANCH  = 1;
    localparam int unsigned T_TAKEN   = 2;
    localparam int unsigned T_UNTAKEN = 3;

    typedef enum logic {
        HZ_CLEAR,
        HZ_LOAD_PEND
    } hz_state_t;

endpackage

// File: rtl/stall_hazard_fsm.sv
module stall_hazard_fsm
    import stall_acct_pkg::*;
#(
    parameter int unsigned NREG  = 16,
    localparam int unsigned REG_W = $clog2(NREG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             step,
    input  logic             is_load,
    input  logic [REG_W-1:0] dst,
    output logic [NREG-1:0]  vis_mask
);

    hz_state_t       state_q, state_d;
    logic [NREG-1:0] pend_q;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            HZ_CLEAR:     if (step && is_load)  state_d = HZ_LOAD_PEND;
            HZ_LOAD_PEND: if (step && !is_load) state_d = HZ_CLEAR;
            default:      state_d = HZ_CLEAR;
        endcase
        if (clr) state_d = HZ_CLEAR;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= HZ_CLEAR;
        else        state_q <= state_d;
    end

    // pending destination mask of the most recent load
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               pend_q <= '0;
        else if (clr)             pend_q <= '0;
        else if (step && is_load) pend_q <= NREG'(1) << dst;
        else if (step)            pend_q <= '0;
    end

    // output: scoreboard seen by the retiring instruction
    always_comb begin
        unique case (state_q)
            HZ_LOAD_PEND: vis_mask = pend_q;
            default:      vis_mask = '0;
        endcase
    end

endmodule

// File: rtl/stall_src_probe.sv
module stall_src_probe #(
    parameter int unsigned NREG  = 16,
    localparam int unsigned REG_W = $clog2(NREG)
) (
    input  logic [NREG-1:0]  scoreboard,
    input  logic [REG_W-1:0] reg_num,
    input  logic             reg_vld,
    input  logic             probe_en,
    output logic             hit
);

    always_comb begin
        hit = probe_en && reg_vld && scoreboard[reg_num];
    end

endmodule

// File: rtl/stall_sat_acc.sv
module stall_sat_acc #(
    parameter int unsigned W  = 32,
    parameter int unsigned IW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          add_en,
    input  logic [IW-1:0] add_val,
    output logic [W-1:0]  total
);

    logic [W:0] sum;

    always_comb begin
        sum = {1'b0, total} + (W+1)'(add_val);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      total <= '0;
        else if (clr)    total <= '0;
        else if (add_en) total <= sum[W] ? {W{1'b1}} : sum[W-1:0];
    end

endmodule

// File: rtl/stall_accounting_monitor.sv
module stall_accounting_monitor
    import stall_acct_pkg::*;
#(
    parameter int unsigned NREG  = 16,
    parameter int unsigned CNT_W = 32,
    localparam int unsigned REG_W = $clog2(NREG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             instr_valid,
    input  logic [2:0]       instr_class,
    input  logic [REG_W-1:0] src_a,
    input  logic             src_a_valid,
    input  logic [REG_W-1:0] src_b,
    input  logic             src_b_valid,
    input  logic [REG_W-1:0] dst_reg,
    input  logic             branch_taken,
    output logic [CNT_W-1:0] load_stall_total,
    output logic [CNT_W-1:0] branch_stall_total,
    output logic [CNT_W-1:0] taken_count,
    output logic [CNT_W-1:0] untaken_count
);

    logic [NREG-1:0]  sb_mask;
    logic             is_arith;
    logic             is_branch;
    logic             is_load;
    logic [REG_W-1:0] src_num [NUM_SRC];
    logic             src_vld [NUM_SRC];
    logic             src_en  [NUM_SRC];
    logic [NUM_SRC-1:0] src_hit;
    logic [INC_W-1:0] inc_val [NUM_TALLY];
    logic             inc_en  [NUM_TALLY];
    logic [CNT_W-1:0] tally   [NUM_TALLY];
    logic [1:0]       hit_cnt;

    always_comb begin
        is_arith  = (instr_class == CLS_EXEC) || (instr_class == CLS_CMP) ||
                    (instr_class == CLS_MAC);
        is_branch = (instr_class == CLS_BRANCH);
        is_load   = (instr_class == CLS_LOAD);
        src_num[0] = src_a;  src_vld[0] = src_a_valid;
        src_num[1] = src_b;  src_vld[1] = src_b_valid;
        src_en[0]  = is_arith || is_branch;
        src_en[1]  = is_arith;
    end

    stall_hazard_fsm #(.NREG(NREG)) u_hazard (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr),
        .step     (instr_valid),
        .is_load  (is_load),
        .dst      (dst_reg),
        .vis_mask (sb_mask)
    );

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_probe
        stall_src_probe #(.NREG(NREG)) u_probe (
            .scoreboard (sb_mask),
            .reg_num    (src_num[s]),
            .reg_vld    (src_vld[s]),
            .probe_en   (src_en[s]),
            .hit        (src_hit[s])
        );
    end

    always_comb begin
        hit_cnt = 2'(src_hit[0]) + 2'(src_hit[1]);
        inc_val[T_LOAD]    = {hit_cnt, 1'b0};
        inc_en[T_LOAD]     = instr_valid && (hit_cnt != 2'd0);
        inc_val[T_BRANCH]  = INC_W'(2);
        inc_en[T_BRANCH]   = instr_valid && is_branch && branch_taken;
        inc_val[T_TAKEN]   = INC_W'(1);
        inc_en[T_TAKEN]    = instr_valid && is_branch && branch_taken;
        inc_val[T_UNTAKEN] = INC_W'(1);
        inc_en[T_UNTAKEN]  = instr_valid && is_branch && !branch_taken;
    end

    for (genvar t = 0; t < NUM_TALLY; t++) begin : g_tally
        stall_sat_acc #(.W(CNT_W), .IW(INC_W)) u_acc (
            .clk     (clk),
            .rst_n   (rst_n),
            .clr     (clr),
            .add_en  (inc_en[t]),
            .add_val (inc_val[t]),
            .total   (tally[t])
        );
    end

    assign load_stall_total   = tally[T_LOAD];
    assign branch_stall_total = tally[T_BRANCH];
    assign taken_count        = tally[T_TAKEN];
    assign untaken_count      = tally[T_UNTAKEN];

endmodule

// File: rtl/stall_accounting_checks.sv
module stall_accounting_checks #(
    parameter int unsigned CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             clr,
    input logic             instr_valid,
    input logic [2:0]       instr_class,
    input logic             branch_taken,
    input logic [CNT_W-1:0] load_stall_total,
    input logic [CNT_W-1:0] branch_stall_total,
    input logic [CNT_W-1:0] taken_count,
    input logic [CNT_W-1:0] untaken_count
);

    assert_clear_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (load_stall_total == '0 && branch_stall_total == '0 &&
                 taken_count == '0 && untaken_count == '0));

    assert_load_monotonic_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> (load_stall_total >= $past(load_stall_total)));

    assert_load_class_free_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && instr_valid && (instr_class == 3'd4 || instr_class == 3'd5))
        |=> $stable(load_stall_total));

    assert_taken_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> ((taken_count - $past(taken_count)) <= CNT_W'(1)));

    assert_untaken_no_penalty_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && instr_valid && instr_class == 3'd3 && !branch_taken)
        |=> $stable(branch_stall_total));

    assert_reserved_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && instr_valid && instr_class[2:1] == 2'b11)
        |=> ($stable(load_stall_total) && $stable(branch_stall_total) &&
             $stable(taken_count) && $stable(untaken_count)));

    assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !instr_valid)
        |=> ($stable(load_stall_total) && $stable(branch_stall_total) &&
             $stable(taken_count) && $stable(untaken_count)));

endmodule

bind stall_accounting_monitor stall_accounting_checks #(.CNT_W(CNT_W)) u_checks (
    .clk                (clk),
    .rst_n              (rst_n),
    .clr                (clr),
    .instr_valid        (instr_valid),
    .instr_class        (instr_class),
    .branch_taken       (branch_taken),
    .load_stall_total   (load_stall_total),
    .branch_stall_total (branch_stall_total),
    .taken_count        (taken_count),
    .untaken_count      (untaken_count)
);

// File: tb/test_stall_accounting_monitor.sv
module test_stall_accounting_monitor;

    localparam int W = 8;
    localparam int MAXV = (1 << W) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clr = 1'b0;
    logic instr_valid = 1'b0;
    logic [2:0] instr_class = 3'd0;
    logic [3:0] src_a = 4'd0, src_b = 4'd0, dst_reg = 4'd0;
    logic src_a_valid = 1'b0, src_b_valid = 1'b0, branch_taken = 1'b0;
    logic [W-1:0] ld_tot, br_tot, tk_cnt, ut_cnt;

    int n_checks = 0;
    int n_fail = 0;
    int e_ld = 0, e_br = 0, e_tk = 0, e_ut = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    stall_accounting_monitor #(.NREG(16), .CNT_W(W)) i_stall_accounting_monitor (
        .clk(clk), .rst_n(rst_n), .clr(clr), .instr_valid(instr_valid),
        .instr_class(instr_class), .src_a(src_a), .src_a_valid(src_a_valid),
        .src_b(src_b), .src_b_valid(src_b_valid), .dst_reg(dst_reg),
        .branch_taken(branch_taken), .load_stall_total(ld_tot),
        .branch_stall_total(br_tot), .taken_count(tk_cnt), .untaken_count(ut_cnt)
    );

    function automatic int sat(input int v);
        return (v > MAXV) ? MAXV : v;
    endfunction

    task automatic check(input string req, input string what, input int got, input int exp);
        n_checks++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, got, exp);
        end
    endtask

    task automatic check_all(input string req);
        check(req, "load_stall_total", int'(ld_tot), e_ld);
        check(req, "branch_stall_total", int'(br_tot), e_br);
        check(req, "taken_count", int'(tk_cnt), e_tk);
        check(req, "untaken_count", int'(ut_cnt), e_ut);
    endtask

    // present one instruction for one cycle; returns at the negedge after capture
    task automatic issue(input logic [2:0] cls, input logic [3:0] a, input logic av,
                         input logic [3:0] b, input logic bv, input logic [3:0] d,
                         input logic tk);
        @(negedge clk);
        instr_valid = 1'b1; instr_class = cls;
        src_a = a; src_a_valid = av; src_b = b; src_b_valid = bv;
        dst_reg = d; branch_taken = tk;
        @(negedge clk);
        instr_valid = 1'b0; src_a_valid = 1'b0; src_b_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_clear();
        @(negedge clk); clr = 1'b1;
        @(negedge clk); clr = 1'b0;
        e_ld = 0; e_br = 0; e_tk = 0; e_ut = 0;
    endtask

    task automatic t_reset_state();
        check_all("R1");
    endtask

    task automatic t_single_hit();
        issue(3'd4, 0, 0, 0, 0, 4'd3, 0);
        check_all("R4");                       // load itself costs nothing
        issue(3'd0, 4'd3, 1, 4'd5, 1, 0, 0);
        e_ld += 2; check_all("R2");
    endtask

    task automatic t_double_hit();
        issue(3'd4, 0, 0, 0, 0, 4'd6, 0);
        issue(3'd1, 4'd6, 1, 4'd6, 1, 0, 0);
        e_ld += 4; check_all("R2");
    endtask

    task automatic t_invalid_src();
        issue(3'd4, 0, 0, 0, 0, 4'd3, 0);
        issue(3'd0, 4'd3, 0, 4'd3, 0, 0, 0);
        check_all("R3");
    endtask

    task automatic t_bubbles_then_window();
        issue(3'd4, 0, 0, 0, 0, 4'd9, 0);
        idle(5);
        check_all("R11");
        issue(3'd2, 4'd1, 1, 4'd9, 1, 0, 0);     // mac reads via source B
        e_ld += 2; check_all("R5");
        issue(3'd0, 4'd9, 1, 4'd9, 1, 0, 0);     // window already spent
        check_all("R5");
    endtask

    task automatic t_intervening_instr();
        issue(3'd4, 0, 0, 0, 0, 4'd7, 0);
        issue(3'd0, 4'd2, 1, 4'd4, 1, 0, 0);
        issue(3'd0, 4'd7, 1, 4'd7, 1, 0, 0);
        check_all("R5");
        issue(3'd4, 0, 0, 0, 0, 4'd1, 0);
        issue(3'd4, 0, 0, 0, 0, 4'd2, 0);        // second load replaces the first
        issue(3'd0, 4'd1, 1, 4'd2, 1, 0, 0);
        e_ld += 2; check_all("R5");
    endtask

    task automatic t_store_and_load_no_probe();
        issue(3'd4, 0, 0, 0, 0, 4'd8, 0);
        issue(3'd5, 4'd8, 1, 4'd8, 1, 0, 0);
        check_all("R4");
        issue(3'd4, 0, 0, 0, 0, 4'd8, 0);
        issue(3'd4, 4'd8, 1, 4'd8, 1, 4'd0, 0);
        check_all("R4");
    endtask

    task automatic t_branch_probe_and_taken();
        issue(3'd4, 0, 0, 0, 0, 4'd4, 0);
        issue(3'd3, 4'd4, 1, 4'd4, 1, 0, 1);     // only source A probed
        e_ld += 2; e_br += 2; e_tk += 1;
        check_all("R6");
        issue(3'd4, 0, 0, 0, 0, 4'd4, 0);
        issue(3'd3, 4'd0, 1, 4'd4, 1, 0, 0);     // source B ignored for branches
        e_ut += 1; check_all("R4");
    endtask

    task automatic t_untaken();
        issue(3'd3, 0, 0, 0, 0, 0, 0);
        issue(3'd3, 0, 0, 0, 0, 0, 0);
        e_ut += 2; check_all("R7");
        issue(3'd0, 0, 0, 0, 0, 0, 1);           // taken flag on non-branch
        check_all("R7");
    endtask

    task automatic t_reserved();
        issue(3'd4, 0, 0, 0, 0, 4'd5, 0);
        issue(3'd6, 4'd5, 1, 4'd5, 1, 0, 1);
        check_all("R8");
        issue(3'd0, 4'd5, 1, 4'd5, 1, 0, 0);     // reserved ended the window
        check_all("R8");
        issue(3'd7, 4'd0, 1, 4'd0, 1, 0, 1);
        check_all("R8");
    endtask

    task automatic t_clear();
        issue(3'd4, 0, 0, 0, 0, 4'd2, 0);
        do_clear();
        check_all("R1");
        issue(3'd0, 4'd2, 1, 4'd2, 1, 0, 0);
        check_all("R10");
        // instruction coinciding with clr is dropped
        @(negedge clk);
        clr = 1'b1; instr_valid = 1'b1; instr_class = 3'd3; branch_taken = 1'b1;
        @(negedge clk);
        clr = 1'b0; instr_valid = 1'b0;
        check_all("R10");
    endtask

    task automatic t_saturation();
        for (int i = 0; i < 63; i++) begin
            issue(3'd4, 0, 0, 0, 0, 4'd11, 0);
            issue(3'd0, 4'd11, 1, 4'd11, 1, 0, 0);
            e_ld = sat(e_ld + 4);
        end
        check("R9", "load_stall_total below limit", int'(ld_tot), 252);
        issue(3'd4, 0, 0, 0, 0, 4'd11, 0);
        issue(3'd0, 4'd11, 1, 4'd11, 1, 0, 0);
        e_ld = sat(e_ld + 4);
        check("R9", "load_stall_total saturated", int'(ld_tot), MAXV);
        for (int i = 0; i < 256; i++) begin
            issue(3'd3, 0, 0, 0, 0, 0, 1);
            e_br = sat(e_br + 2); e_tk = sat(e_tk + 1);
        end
        check_all("R9");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_single_hit();
        t_double_hit();
        t_invalid_src();
        t_bubbles_then_window();
        t_intervening_instr();
        t_store_and_load_no_probe();
        t_branch_probe_and_taken();
        t_untaken();
        t_reserved();
        t_clear();
        t_saturation();
        done = 1'b1;
    end

    initial begin
        fork
            begin
                wait (done);
            end
            begin
                repeat (100000) @(posedge clk);
                n_checks++;
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule